// File: doc/BRIEF.md
# Multi-Level Central Bus Arbiter with Deglitched Busy Release

This block is the central arbiter of a shared backplane bus. Masters raise active-low requests on four request levels. The arbiter answers with one grant per level, and each grant feeds that level's daisy chain. While a master owns the bus it holds a shared, wire-ORed, active-low busy line low. The arbiter issues another grant only after that line has been released.

A noise spike on the busy line can look like a release. If the arbiter acted on such a spike, it would grant the bus to a second master while the first one still drives it. To prevent this, the busy line passes through a filter first. The filter accepts a release only after it has seen the line high on several consecutive clock samples. Any low sample restarts the count and marks the bus busy again.

A static mode input selects the level-selection scheme. In fixed-priority mode the highest-numbered level always wins. In round-robin mode the search starts one level below the most recent winner and wraps around.

Top module: `bus_level_arbiter`

## Requirements
- R1: Requests are active low, one bit per level, with bit i belonging to level i (four levels). A grant is active high on `gnt_o[i]` for level i, and at most one grant bit is ever set.
- R2: With `rr_mode_i` = 0, the winner is the highest-numbered level whose request is low.
- R3: With `rr_mode_i` = 1, the search order starts at the level one below the last granted level, counts down and wraps from 0 to 3. The last granted level is therefore searched last.
- R4: A release counts only after `bbsy_n_i` has been sampled high on 3 consecutive rising edges. The earliest grant appears on the edge after the third such sample, and no grant is present before that edge.
- R5: A single low sample of `bbsy_n_i` restarts the release count and marks the bus busy on the next edge. A high pulse of 1 or 2 cycles therefore never produces a grant.
- R6: A grant is held until the filtered busy is seen asserted. It is removed on the second rising edge after `bbsy_n_i` is first sampled low.
- R7: No new grant is issued while the filtered busy is asserted or while another grant is outstanding.
- R8: With no request pending, no grant is issued even when the bus is free. Requests presented while the bus is busy produce no grant.
- R9: The synchronous active-high `rst` clears all grants, marks the bus busy and sets the round-robin pointer to level 0. The first round-robin search after reset therefore begins at level 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode_i | input | 1 | 0 = fixed priority, 1 = round robin; static |
| req_n_i | input | 4 | Active-low bus requests, bit i = level i |
| bbsy_n_i | input | 1 | Wire-ORed active-low bus-busy line |
| gnt_o | output | 4 | Active-high grant to the daisy chain of each level |

## Verification
The selection logic is swept over all sixteen request patterns in fixed-priority mode, which separates a correct priority order from a reversed or shifted one. In round-robin mode the same sweep is repeated from each of the four possible last-granted levels, so that a wrong starting point or wrong wrap direction shows up as a different winner. Busy-line pulses one and two cycles long, with requests pending, distinguish a filter that restarts its count from one that merely accumulates. A reset in the middle of the run, taken while the pointer sits on another level, shows whether the pointer returns to level 0.

// File: rtl/bus_level_arbiter.sv
module bus_level_arbiter #(
  parameter int LEVELS  = 4,
  parameter int REL_CNT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rr_mode_i,
  input  logic [LEVELS-1:0] req_n_i,
  input  logic              bbsy_n_i,
  output logic [LEVELS-1:0] gnt_o
);
  localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int CW = $clog2(REL_CNT + 1);

  logic [CW-1:0]     rel_cnt_q;
  logic              busy_q;
  logic [LW-1:0]     last_q;
  logic [LEVELS-1:0] gnt_q;
  logic [LW-1:0]     fix_idx;
  logic [LW-1:0]     rr_idx;
  logic              rr_hit;
  logic [LW-1:0]     sel_idx;

  wire [LEVELS-1:0] req     = ~req_n_i;
  wire              any_req = |req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_cnt_q <= '0;
      busy_q    <= 1'b1;
    end else if (!bbsy_n_i) begin
      rel_cnt_q <= '0;
      busy_q    <= 1'b1;
    end else if (rel_cnt_q == CW'(REL_CNT - 1)) begin
      busy_q    <= 1'b0;
    end else begin
      rel_cnt_q <= rel_cnt_q + 1'b1;
    end
  end

  always_comb begin
    fix_idx = '0;
    for (int i = 0; i < LEVELS; i++)
      if (req[i]) fix_idx = LW'(i);
  end

  always_comb begin
    int j;
    j      = 0;
    rr_idx = '0;
    rr_hit = 1'b0;
    for (int k = 1; k <= LEVELS; k++) begin
      j = (int'(last_q) + LEVELS - k) % LEVELS;
      if (!rr_hit && req[j]) begin
        rr_idx = LW'(j);
        rr_hit = 1'b1;
      end
    end
  end

  assign sel_idx = rr_mode_i ? rr_idx : fix_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      last_q <= '0;
    end else if (|gnt_q) begin
      if (busy_q) gnt_q <= '0;
    end else if (!busy_q && any_req) begin
      gnt_q  <= LEVELS'(1) << sel_idx;
      last_q <= sel_idx;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/bus_level_arbiter_chk.sv
module bus_level_arbiter_chk #(
  parameter int LEVELS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [LEVELS-1:0] req_n_i,
  input logic              bbsy_n_i,
  input logic [LEVELS-1:0] gnt_o,
  input logic              busy_f
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o)); // R1
  AST_GRANT_NEEDS_FREE: assert property (@(posedge clk) disable iff (rst)
    $rose(|gnt_o) |-> !$past(busy_f)); // R7
  AST_RELEASE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_f) |-> $past(bbsy_n_i)); // R4
  AST_LOW_SAMPLE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !bbsy_n_i |=> busy_f); // R5
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((|gnt_o) && !busy_f) |=> $stable(gnt_o)); // R6
  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (rst)
    ((|gnt_o) && busy_f) |=> (gnt_o == '0)); // R6
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(|gnt_o) |-> ((gnt_o & ~$past(req_n_i)) != '0)); // R8
endmodule

bind bus_level_arbiter bus_level_arbiter_chk #(.LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst(rst), .req_n_i(req_n_i), .bbsy_n_i(bbsy_n_i),
  .gnt_o(gnt_o), .busy_f(busy_q)
);

// File: tb/bus_level_arbiter_tb.sv
module bus_level_arbiter_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rr_mode = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic       bbsy_n = 1'b0;
  logic [3:0] gnt;
  int n_chk = 0;
  int n_bad = 0;
  int last_m = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_level_arbiter u_dut (
    .clk(clk), .rst(rst), .rr_mode_i(rr_mode), .req_n_i(req_n),
    .bbsy_n_i(bbsy_n), .gnt_o(gnt)
  );

  task automatic chk(input string r, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt=%b expected %b", r, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int pick(input logic [3:0] p, input bit rr, input int last);
    int w;
    w = -1;
    if (!rr) begin
      for (int i = 0; i < 4; i++) if (p[i]) w = i;
    end else begin
      for (int k = 4; k >= 1; k--) if (p[(last + 4 - k) % 4]) w = (last + 4 - k) % 4;
    end
    return w;
  endfunction

  task automatic round(input logic [3:0] p, input string tag);
    int w;
    logic [3:0] e;
    w = pick(p, rr_mode, last_m);
    e = (w < 0) ? 4'h0 : 4'(1 << w);
    req_n  = ~p;
    bbsy_n = 1'b1;
    edges(3);
    chk("R4 no grant before third high sample", gnt, 4'h0);
    edges(1);
    chk(tag, gnt, e);
    if (w >= 0) last_m = w;
    bbsy_n = 1'b0;
    req_n  = 4'hF;
    edges(1);
    chk("R6 grant held one edge after busy low", gnt, e);
    edges(1);
    chk("R6 grant dropped after filtered busy", gnt, 4'h0);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    @(negedge clk);
    req_n  = 4'h0;
    bbsy_n = 1'b1;
    edges(5);
    chk("R9 no grant during reset", gnt, 4'h0);
    rst    = 1'b0;
    bbsy_n = 1'b0;
    req_n  = 4'hF;
    edges(1);
    chk("R9 no grant out of reset", gnt, 4'h0);

    rr_mode = 1'b1;
    round(4'hF, "R9 first round-robin search starts at level 3");

    rr_mode = 1'b0;
    for (int p = 0; p < 16; p++) round(4'(p), "R2 fixed priority (R1 one-hot grant)");

    rr_mode = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int p = 1; p < 16; p++) begin
        round(4'(1 << s), "R3 prime pointer");
        round(4'(p), "R3 round-robin order (R1 one-hot grant)");
      end

    req_n = ~4'b0101;
    edges(5);
    chk("R8 requests ignored while busy", gnt, 4'h0);
    for (int w = 1; w <= 2; w++) begin
      bbsy_n = 1'b1;
      edges(w);
      chk("R5 no grant during short high pulse", gnt, 4'h0);
      bbsy_n = 1'b0;
      edges(4);
      chk("R5 short high pulse gives no grant", gnt, 4'h0);
    end
    round(4'b0101, "R3 grant after full release");

    bbsy_n = 1'b1;
    req_n  = 4'hF;
    edges(8);
    chk("R8 free bus without request gives no grant", gnt, 4'h0);
    bbsy_n = 1'b0;
    edges(1);

    round(4'b0010, "R3 prime pointer before reset");
    rst = 1'b1;
    edges(2);
    rst = 1'b0;
    last_m = 0;
    round(4'hF, "R9 pointer back at level 0 after reset");

    report();
  end
endmodule